// File: doc/BRIEF.md
# Line-Buffered Write Port Controller

This block is the write side of a field memory that is filled one line at a time. Incoming words go into a one-line staging register at a word pointer that moves along the line. A transfer command copies the whole staging register into a small line store, at the line named by the current line pointer. The line pointer is moved by single-cycle commands, and a stored line address is shifted in one bit per clock.

A control word of three inputs picks the operation for each clock. With the command input high, the increment and address-enable inputs select one of four operations: commit, clear, next line or jump to the stored address. With the command input low and address enable high, one address bit is shifted in. Otherwise the write enable and input enable steer the data path. Input enable masks the store while the pointer keeps moving, so a region of a line can be skipped without disturbing it.

A synchronous read port on the line store lets the surrounding logic fetch any committed word.

Top module: `fm_wr_port`

## Requirements
- R1: With `cmd_rst` low and `addr_en` high, each rising edge shifts `addr_bit` into the 9-bit stored line address, most significant bit first. A later jump makes that address visible on `line_ptr`.
- R2: With `cmd_rst` high and both `cmd_inc` and `addr_en` low, the cycle is a commit. `commit` is high for exactly the following cycle, and at the next edge the line store entry `line_ptr mod LINES` takes the full staging register. Both pointers stay unchanged.
- R3: With `cmd_rst` high, `cmd_inc` low and `addr_en` high, both pointers go to zero and the stored line address is left unchanged.
- R4: With `cmd_rst` high, `cmd_inc` high and `addr_en` low, `line_ptr` increases by one (modulo 512) and `word_ptr` goes to zero.
- R5: With `cmd_rst`, `cmd_inc` and `addr_en` all high, `line_ptr` takes the stored line address and `word_ptr` goes to zero.
- R6: In a data cycle (`cmd_rst` and `addr_en` low) with `wr_en` and `in_en` high, `din` is stored at staging word `word_ptr` and the pointer advances by one.
- R7: In a data cycle with `wr_en` high and `in_en` low, the pointer advances and the staging word keeps its earlier contents.
- R8: In a data cycle with `wr_en` low, neither pointer moves and nothing is stored.
- R9: `word_ptr` stops at `WORDS-1` (959 by default). Further writes land on the last word without wrapping.
- R10: Staged words do not reach the line store until a commit is issued.
- R11: Reset clears both pointers, the stored line address and the staging register, and holds `commit` low.
- R12: `rd_data` shows the line store word at (`rd_line`, `rd_word`) one clock after they are sampled.
- R13: In address-shift and command cycles, `wr_en` and `in_en` have no effect: no word is stored and the word pointer does not advance from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rst | input | 1 | Selects a single-cycle command |
| cmd_inc | input | 1 | Command select bit: increment |
| addr_en | input | 1 | Address shift enable; command select bit |
| addr_bit | input | 1 | Serial line address bit |
| wr_en | input | 1 | Write enable; advances the word pointer |
| in_en | input | 1 | Input enable; masks the store when low |
| din | input | 12 | Input word |
| rd_line | input | 2 | Line store read line |
| rd_word | input | 10 | Line store read word |
| rd_data | output | 12 | Line store read data |
| line_ptr | output | 9 | Current line pointer |
| word_ptr | output | 10 | Current word pointer |
| commit | output | 1 | One-cycle commit strobe to the line store |

## Verification
The properties assume that every control input is 0 or 1 at each rising edge after reset, and that `rd_word` stays below `WORDS`. The bench meets these assumptions by changing all inputs on the falling edge and using only in-range read addresses. Back-to-back commands are legal and the properties allow for them. The bench issues commands one at a time so that each pointer move can be checked on its own.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SET,
    OP_XFER,
    OP_CLR,
    OP_NEXT,
    OP_JUMP,
    OP_WRITE,
    OP_SKIP
  } op_e;
endpackage

// File: rtl/fm_wr_decode.sv
module fm_wr_decode
  import fm_wr_pkg::*;
(
  input  logic cmd_rst,
  input  logic cmd_inc,
  input  logic addr_en,
  input  logic wr_en,
  input  logic in_en,
  output op_e  op
);
  // Command cycles take priority over address shifting and data movement.
  always_comb begin
    if (cmd_rst) begin
      unique case ({cmd_inc, addr_en})
        2'b00:   op = OP_XFER;
        2'b01:   op = OP_CLR;
        2'b10:   op = OP_NEXT;
        default: op = OP_JUMP;
      endcase
    end else if (addr_en) begin
      op = OP_SET;
    end else if (wr_en) begin
      op = in_en ? OP_WRITE : OP_SKIP;
    end else begin
      op = OP_IDLE;
    end
  end
endmodule

// File: rtl/fm_wr_addr.sv
module fm_wr_addr
  import fm_wr_pkg::*;
#(
  parameter int WORDS = 960,
  parameter int LAW   = 9,
  localparam int WW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          addr_bit,
  output logic [LAW-1:0] line_ptr,
  output logic [WW-1:0]  word_ptr
);
  localparam logic [WW-1:0] LAST = WW'(WORDS - 1);

  logic [LAW-1:0] line_q, line_n;
  logic [LAW-1:0] addr_q, addr_n;
  logic [WW-1:0]  word_q, word_n;
  logic           line_ce, word_ce, addr_ce;

  always_comb begin
    line_n  = line_q;
    word_n  = word_q;
    addr_n  = addr_q;
    line_ce = 1'b0;
    word_ce = 1'b0;
    addr_ce = 1'b0;
    unique case (op)
      OP_SET: begin
        addr_n  = {addr_q[LAW-2:0], addr_bit};
        addr_ce = 1'b1;
      end
      OP_CLR: begin
        line_n  = '0;
        word_n  = '0;
        line_ce = 1'b1;
        word_ce = 1'b1;
      end
      OP_NEXT: begin
        line_n  = line_q + LAW'(1);
        word_n  = '0;
        line_ce = 1'b1;
        word_ce = 1'b1;
      end
      OP_JUMP: begin
        line_n  = addr_q;
        word_n  = '0;
        line_ce = 1'b1;
        word_ce = 1'b1;
      end
      OP_WRITE, OP_SKIP: begin
        word_n  = word_q + WW'(1);
        word_ce = (word_q != LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      word_q <= '0;
      addr_q <= '0;
    end else begin
      if (line_ce) line_q <= line_n;
      if (word_ce) word_q <= word_n;
      if (addr_ce) addr_q <= addr_n;
    end
  end

  assign line_ptr = line_q;
  assign word_ptr = word_q;
endmodule

// File: rtl/fm_wr_linereg.sv
module fm_wr_linereg
  import fm_wr_pkg::*;
#(
  parameter int WORDS = 960,
  parameter int DW    = 12,
  parameter int LIDX  = 2,
  localparam int WW   = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  op_e                        op,
  input  logic [WW-1:0]              word_ptr,
  input  logic [DW-1:0]              din,
  input  logic [LIDX-1:0]            line_sel,
  output logic [WORDS-1:0][DW-1:0]   line_data,
  output logic                       commit,
  output logic [LIDX-1:0]            commit_line
);
  logic [WORDS-1:0][DW-1:0] stage_q;
  logic                     store_ce;
  logic                     commit_n;
  logic [LIDX-1:0]          cline_q;

  assign store_ce = (op == OP_WRITE);
  assign commit_n = (op == OP_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (store_ce) begin
      stage_q[word_ptr] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit  <= 1'b0;
      cline_q <= '0;
    end else begin
      commit <= commit_n;
      if (commit_n) cline_q <= line_sel;
    end
  end

  assign line_data   = stage_q;
  assign commit_line = cline_q;
endmodule

// File: rtl/fm_wr_store.sv
module fm_wr_store #(
  parameter int WORDS = 960,
  parameter int DW    = 12,
  parameter int LINES = 4,
  localparam int WW   = $clog2(WORDS),
  localparam int LIDX = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [LIDX-1:0]          commit_line,
  input  logic [WORDS-1:0][DW-1:0] line_data,
  input  logic [LIDX-1:0]          rd_line,
  input  logic [WW-1:0]            rd_word,
  output logic [DW-1:0]            rd_data
);
  logic [WORDS-1:0][DW-1:0] mem [LINES];
  logic [WORDS-1:0][DW-1:0] rd_row;

  always_ff @(posedge clk) begin
    if (commit) mem[commit_line] <= line_data;
  end

  assign rd_row = mem[rd_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_row[rd_word];
  end
endmodule

// File: rtl/fm_wr_port.sv
module fm_wr_port
  import fm_wr_pkg::*;
#(
  parameter int WORDS = 960,
  parameter int DW    = 12,
  parameter int LINES = 4,
  parameter int LAW   = 9,
  localparam int WW   = $clog2(WORDS),
  localparam int LIDX = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_rst,
  input  logic            cmd_inc,
  input  logic            addr_en,
  input  logic            addr_bit,
  input  logic            wr_en,
  input  logic            in_en,
  input  logic [DW-1:0]   din,
  input  logic [LIDX-1:0] rd_line,
  input  logic [WW-1:0]   rd_word,
  output logic [DW-1:0]   rd_data,
  output logic [LAW-1:0]  line_ptr,
  output logic [WW-1:0]   word_ptr,
  output logic            commit
);
  op_e                      op;
  logic [WORDS-1:0][DW-1:0] line_data;
  logic [LIDX-1:0]          commit_line;

  fm_wr_decode u_dec (
    .cmd_rst (cmd_rst),
    .cmd_inc (cmd_inc),
    .addr_en (addr_en),
    .wr_en   (wr_en),
    .in_en   (in_en),
    .op      (op)
  );

  fm_wr_addr #(.WORDS(WORDS), .LAW(LAW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .addr_bit (addr_bit),
    .line_ptr (line_ptr),
    .word_ptr (word_ptr)
  );

  fm_wr_linereg #(.WORDS(WORDS), .DW(DW), .LIDX(LIDX)) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .word_ptr    (word_ptr),
    .din         (din),
    .line_sel    (line_ptr[LIDX-1:0]),
    .line_data   (line_data),
    .commit      (commit),
    .commit_line (commit_line)
  );

  fm_wr_store #(.WORDS(WORDS), .DW(DW), .LINES(LINES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_line (commit_line),
    .line_data   (line_data),
    .rd_line     (rd_line),
    .rd_word     (rd_word),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/fm_wr_port_chk.sv
module fm_wr_port_chk #(
  parameter int WORDS = 960,
  parameter int LAW   = 9,
  localparam int WW   = $clog2(WORDS)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_rst,
  input logic           cmd_inc,
  input logic           addr_en,
  input logic           wr_en,
  input logic [LAW-1:0] line_ptr,
  input logic [WW-1:0]  word_ptr,
  input logic           commit
);
  localparam logic [WW-1:0] LAST = WW'(WORDS - 1);

  p_commit_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cmd_rst && !cmd_inc && !addr_en));

  p_commit_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && !cmd_inc && !addr_en) |=> commit && $stable(line_ptr) && $stable(word_ptr));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && !cmd_inc && addr_en) |=> (line_ptr == '0) && (word_ptr == '0));

  p_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && cmd_inc && !addr_en) |=>
      (line_ptr == LAW'($past(line_ptr) + LAW'(1))) && (word_ptr == '0));

  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && cmd_inc && addr_en) |=> (word_ptr == '0));

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rst && !addr_en && wr_en && (word_ptr != LAST)) |=>
      (word_ptr == WW'($past(word_ptr) + WW'(1))) && $stable(line_ptr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rst && !addr_en && !wr_en) |=> $stable(word_ptr) && $stable(line_ptr));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_ptr <= LAST);

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rst && !addr_en && wr_en && (word_ptr == LAST)) |=> (word_ptr == LAST));

  p_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rst && addr_en) |=> $stable(word_ptr) && $stable(line_ptr));
endmodule

bind fm_wr_port fm_wr_port_chk #(.WORDS(WORDS), .LAW(LAW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_rst  (cmd_rst),
  .cmd_inc  (cmd_inc),
  .addr_en  (addr_en),
  .wr_en    (wr_en),
  .line_ptr (line_ptr),
  .word_ptr (word_ptr),
  .commit   (commit)
);

// File: tb/fm_wr_port_test.sv
module fm_wr_port_test;
  localparam int WORDS = 960;
  localparam int LINES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_rst = 0, cmd_inc = 0, addr_en = 0, addr_bit = 0;
  logic        wr_en = 0, in_en = 0;
  logic [11:0] din = '0;
  logic [1:0]  rd_line = '0;
  logic [9:0]  rd_word = '0;
  logic [11:0] rd_data;
  logic [8:0]  line_ptr;
  logic [9:0]  word_ptr;
  logic        commit;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int m_line = 0, m_word = 0, m_addr = 0;
  int m_stage [WORDS];
  int m_store [LINES][WORDS];
  int m_commit = 0;

  // scoreboard for the read port
  int    exp_q[$];
  string tag_q[$];
  logic  rd_req = 0, rd_req_d = 0;

  always #4 clk = ~clk;

  fm_wr_port uut (
    .clk(clk), .rst_n(rst_n), .cmd_rst(cmd_rst), .cmd_inc(cmd_inc),
    .addr_en(addr_en), .addr_bit(addr_bit), .wr_en(wr_en), .in_en(in_en),
    .din(din), .rd_line(rd_line), .rd_word(rd_word), .rd_data(rd_data),
    .line_ptr(line_ptr), .word_ptr(word_ptr), .commit(commit)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rd_req_d) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'(rd_data), e);
    end
  end

  // one clock of stimulus, with the reference model advanced by the rules
  task automatic cyc(bit c, bit i, bit a, bit b, bit w, bit e, int d);
    cmd_rst = c; cmd_inc = i; addr_en = a; addr_bit = b;
    wr_en = w; in_en = e; din = 12'(d);
    m_commit = 0;
    if (c) begin
      case ({i, a})
        2'b00: begin
          for (int k = 0; k < WORDS; k++) m_store[m_line % LINES][k] = m_stage[k];
          m_commit = 1;
        end
        2'b01: begin m_line = 0; m_word = 0; end
        2'b10: begin m_line = (m_line + 1) % 512; m_word = 0; end
        default: begin m_line = m_addr; m_word = 0; end
      endcase
    end else if (a) begin
      m_addr = ((m_addr << 1) | int'(b)) & 511;
    end else if (w) begin
      if (e) m_stage[m_word] = d & 12'hfff;
      if (m_word < WORDS - 1) m_word++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ptrs(string tag);
    check({tag, " line_ptr"}, int'(line_ptr), m_line);
    check({tag, " word_ptr"}, int'(word_ptr), m_word);
  endtask

  task automatic shift_addr(int v, bit w);
    for (int k = 8; k >= 0; k--) cyc(0, 0, 1, v[k], w, 1, 777);
  endtask

  task automatic rd(int l, int w, string tag);
    rd_line = 2'(l); rd_word = 10'(w);
    exp_q.push_back(m_store[l][w]);
    tag_q.push_back(tag);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  initial begin
    for (int k = 0; k < WORDS; k++) m_stage[k] = 0;
    for (int l = 0; l < LINES; l++) for (int k = 0; k < WORDS; k++) m_store[l][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    ptrs("R11");
    check("R11 commit", int'(commit), 0);
    cyc(1, 1, 1, 0, 0, 0, 0);            // jump to cleared address
    ptrs("R11 jump");
    cyc(1, 0, 0, 0, 0, 0, 0);            // commit cleared staging register
    idle();
    rd(0, 0, "R11 stage cleared");
    rd(0, 5, "R11 stage cleared");
    // R1 / R13: shift 3 while write enables are high
    shift_addr(3, 1);
    ptrs("R13 set cycles");
    cyc(1, 1, 1, 0, 1, 1, 55);           // R5 jump, write ignored
    ptrs("R5 jump to 3");
    check("R1 line_ptr", int'(line_ptr), 3);
    // R6 writes
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 1, 1, 100 + k);
    ptrs("R6");
    // R7 masked
    cyc(0, 0, 0, 0, 1, 0, 900); cyc(0, 0, 0, 0, 1, 0, 901);
    ptrs("R7");
    // R8 idle with data
    cyc(0, 0, 0, 0, 0, 1, 902); cyc(0, 0, 0, 0, 0, 1, 903);
    ptrs("R8");
    // R10 store untouched before commit
    rd(0, 0, "R10");
    rd(0, 3, "R10");
    // R2 commit
    cyc(1, 0, 0, 0, 1, 1, 904);
    check("R2 commit high", int'(commit), 1);
    ptrs("R2 pointers");
    idle();
    check("R2 commit low", int'(commit), 0);
    for (int k = 0; k < 13; k++) rd(3, k, "R2/R7/R12 line 3");
    // R3 clear keeps stored address
    cyc(1, 0, 1, 0, 0, 0, 0);
    ptrs("R3 clear");
    cyc(1, 1, 1, 0, 0, 0, 0);
    ptrs("R3 jump back");
    check("R3 stored address", int'(line_ptr), 3);
    // R4 next line and wrap
    cyc(1, 1, 0, 0, 0, 0, 0);
    ptrs("R4 next");
    shift_addr(511, 0);
    cyc(1, 1, 1, 0, 0, 0, 0);
    ptrs("R5 jump 511");
    cyc(1, 1, 0, 0, 0, 0, 0);
    ptrs("R4 wrap");
    check("R4 wrap value", int'(line_ptr), 0);
    // R9 saturation on line 2 (stored address 6 -> store line 2)
    shift_addr(6, 0);
    cyc(1, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < WORDS + 5; k++) cyc(0, 0, 0, 0, 1, 1, (k * 7 + 1) & 12'hfff);
    ptrs("R9 saturate");
    check("R9 last word", int'(word_ptr), WORDS - 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    idle();
    rd(2, 0, "R9 first");
    rd(2, 958, "R9 before last");
    rd(2, 959, "R9 last");
    rd(3, 1, "R2 other line kept");
    idle();
    idle();
    if (exp_q.size() != 0) check("R12 pending reads", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule